// File: doc/BRIEF.md
# Flash Command and Status-Poll Controller

This block sits on the host side of a byte-wide parallel flash device. A user request asks for one of three jobs: write a single byte, erase a set of sectors given as a bit mask, or erase the whole array. The controller issues the unlock and command write cycles the flash expects, one write per clock. It then reads status bytes from the flash until the embedded operation reports an outcome, and returns a single pass/fail result.

Two ways of detecting completion are offered, chosen per request. Data polling compares bit 7 against the value expected at the end of the job. Toggle polling watches whether bit 6 keeps changing between consecutive reads. In both modes, bit 5 (time limit exceeded) triggers a final recheck, because it can change in the same read as the completion bit. A poll-count limit bounds the wait. On failure, a reset command is written so that the rest of the array stays usable. When several sectors are queued, an optional window check reads bit 3 after each added sector and marks the sectors the flash may not have taken.

The flash side is a simple synchronous bus. Write address and data are valid while the write strobe is high, and the flash returns read data one clock after the read strobe.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: After reset and whenever idle, `req_ready` is 1, both bus strobes are 0 and `done_valid` is 0; a request is taken in a cycle where `req_valid` and `req_ready` are both 1.
- R2: Request code 0 (byte write) issues four write cycles in consecutive clocks: AAh at 5555h, 55h at 2AAAh, A0h at 5555h, then `req_data` at `req_addr`.
- R3: Request code 1 (sector erase) issues AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and then 30h at the base of the lowest-numbered sector in the mask. It then writes 30h at the base of every other masked sector in ascending order. Sector n covers the addresses whose top SECT_BITS bits equal n, and its base has all lower bits at zero.
- R4: Request code 2 (chip erase) issues the same first five writes as R3 and ends with 10h at 5555h.
- R5: Status reads go to the target address for a byte write, to the base of the lowest masked sector for a sector erase, and to address 0 for a chip erase. In data-poll mode (`req_toggle`=0), a read whose bit 7 equals the expected value (bit 7 of the data for a byte write, 1 for an erase) ends the job with pass. A read with a bit-7 mismatch and bit 5 at 0 is followed by another read.
- R6: In data-poll mode, a read with a bit-7 mismatch and bit 5 at 1 is followed by exactly one more read. The job passes if that read's bit 7 matches and fails otherwise.
- R7: In toggle mode (`req_toggle`=1), the job passes when bit 6 is equal in two consecutive reads. If bit 6 changed and bit 5 is 1, two more reads follow, and the job fails if bit 6 differs between those two reads and passes otherwise.
- R8: Every failed job writes F0h at address 0, in the cycle just before `done_valid`.
- R9: When the number of ordinary status reads reaches POLL_LIMIT without an outcome, the job fails. Recheck reads are not counted.
- R10: With BIT3_CHECK set, each added sector write (after the first sector) is followed by one read at that sector's base. If bit 3 of that read is 1, the sector's bit is set in `done_rejected`.
- R11: A sector erase with an empty mask, or request code 3, completes with fail and produces no bus cycle at all.
- R12: The two strobes are never high together, `req_ready` is 0 during any bus cycle, and `done_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_op | input | 2 | 0 byte write, 1 sector erase, 2 chip erase, 3 reserved |
| req_addr | input | AW | Byte address for a byte write |
| req_data | input | 8 | Byte to write |
| req_sectors | input | 2**SECT_BITS | Sector mask for sector erase |
| req_toggle | input | 1 | 1 selects toggle polling, 0 data polling |
| done_valid | output | 1 | One-cycle completion pulse |
| done_pass | output | 1 | Job outcome, valid with done_valid |
| done_rejected | output | 2**SECT_BITS | Sectors flagged by the window check |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read data, one clock after fl_re |

## Verification
The bench drives a flash model that returns scripted status: early completion, a late bit-5 with success on the recheck, a bit-5 hang, and a flash that never finishes. Each script is run under both polling modes. A controller that skipped the bit-7 or bit-6 recheck would report fail on the late-completion script. One that ignored the limit would poll forever on the never-finishing script, and one that left out the reset write would miss the F0h write the scoreboard expects. Sector erase runs check the ascending order of added sectors and use the bit-3 model to mark late additions. The empty-mask and reserved-code requests check that no bus cycle at all leaks onto the flash.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_CHIP = 2'd2
   } nvm_op_e;

   typedef enum logic [1:0] {
      V_PASS,
      V_FAIL,
      V_AGAIN,
      V_NEXT
   } nvm_verdict_e;

   localparam logic [15:0] UNLOCK_A  = 16'h5555;
   localparam logic [15:0] UNLOCK_B  = 16'h2AAA;
   localparam logic [7:0]  KEY_A     = 8'hAA;
   localparam logic [7:0]  KEY_B     = 8'h55;
   localparam logic [7:0]  CMD_PROG  = 8'hA0;
   localparam logic [7:0]  CMD_SETUP = 8'h80;
   localparam logic [7:0]  CMD_CHIP  = 8'h10;
   localparam logic [7:0]  CMD_SECT  = 8'h30;
   localparam logic [7:0]  CMD_RESET = 8'hF0;

   localparam int BIT_DONE  = 7;
   localparam int BIT_TOG   = 6;
   localparam int BIT_LIMIT = 5;
   localparam int BIT_WIN   = 3;

   localparam int STEP_W = 3;

endpackage

// File: rtl/nvm_cmd_rom.sv
module nvm_cmd_rom
   import nvm_prog_pkg::*;
#(
   parameter int AW = 19
)(
   input  nvm_op_e            op,
   input  logic [STEP_W-1:0]  step,
   input  logic [AW-1:0]      tgt_addr,
   input  logic [7:0]         tgt_data,
   input  logic [AW-1:0]      sect_base,
   output logic [AW-1:0]      cmd_addr,
   output logic [7:0]         cmd_data,
   output logic               last
);

   function automatic logic [AW-1:0] widen(input logic [15:0] a);
      logic [AW-1:0] r;
      r = '0;
      r[15:0] = a;
      return r;
   endfunction

   always_comb begin
      cmd_addr = widen(UNLOCK_A);
      cmd_data = KEY_A;
      last     = 1'b0;
      if (op == OP_PROG) begin
         case (step)
            3'd0: begin cmd_addr = widen(UNLOCK_A); cmd_data = KEY_A;    end
            3'd1: begin cmd_addr = widen(UNLOCK_B); cmd_data = KEY_B;    end
            3'd2: begin cmd_addr = widen(UNLOCK_A); cmd_data = CMD_PROG; end
            default: begin
               cmd_addr = tgt_addr;
               cmd_data = tgt_data;
               last     = 1'b1;
            end
         endcase
      end else begin
         case (step)
            3'd0: begin cmd_addr = widen(UNLOCK_A); cmd_data = KEY_A;     end
            3'd1: begin cmd_addr = widen(UNLOCK_B); cmd_data = KEY_B;     end
            3'd2: begin cmd_addr = widen(UNLOCK_A); cmd_data = CMD_SETUP; end
            3'd3: begin cmd_addr = widen(UNLOCK_A); cmd_data = KEY_A;     end
            3'd4: begin cmd_addr = widen(UNLOCK_B); cmd_data = KEY_B;     end
            default: begin
               last = 1'b1;
               if (op == OP_CHIP) begin
                  cmd_addr = widen(UNLOCK_A);
                  cmd_data = CMD_CHIP;
               end else begin
                  cmd_addr = sect_base;
                  cmd_data = CMD_SECT;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/nvm_sector_pick.sv
module nvm_sector_pick #(
   parameter int N  = 8,
   parameter int IW = 3
)(
   input  logic [N-1:0]  mask,
   output logic [IW-1:0] idx,
   output logic          any
);

   logic [N:0]   seen;
   logic [N-1:0] first;

   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign seen[i+1] = seen[i] | mask[i];
      assign first[i]  = mask[i] & ~seen[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (first[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/nvm_status_eval.sv
module nvm_status_eval
   import nvm_prog_pkg::*;
(
   input  logic          toggle,
   input  logic [1:0]    stage,
   input  logic          have_prev,
   input  logic          prev6,
   input  logic          exp7,
   input  logic          limit_hit,
   input  logic [7:0]    rd,
   output nvm_verdict_e  verdict
);

   always_comb begin
      verdict = V_AGAIN;
      if (!toggle) begin
         if (rd[BIT_DONE] == exp7)  verdict = V_PASS;
         else if (stage != 2'd0)    verdict = V_FAIL;
         else if (rd[BIT_LIMIT])    verdict = V_NEXT;
         else if (limit_hit)        verdict = V_FAIL;
         else                       verdict = V_AGAIN;
      end else begin
         case (stage)
            2'd0: begin
               if (have_prev && (rd[BIT_TOG] == prev6)) verdict = V_PASS;
               else if (have_prev && rd[BIT_LIMIT])     verdict = V_NEXT;
               else if (limit_hit)                      verdict = V_FAIL;
               else                                     verdict = V_AGAIN;
            end
            2'd1:    verdict = V_NEXT;
            default: verdict = (rd[BIT_TOG] == prev6) ? V_PASS : V_FAIL;
         endcase
      end
   end

endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
   import nvm_prog_pkg::*;
#(
   parameter int AW         = 19,
   parameter int SECT_BITS  = 3,
   parameter int POLL_LIMIT = 4096,
   parameter bit BIT3_CHECK = 1'b1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   output logic                        req_ready,
   input  logic [1:0]                  req_op,
   input  logic [AW-1:0]               req_addr,
   input  logic [7:0]                  req_data,
   input  logic [(1<<SECT_BITS)-1:0]   req_sectors,
   input  logic                        req_toggle,
   output logic                        done_valid,
   output logic                        done_pass,
   output logic [(1<<SECT_BITS)-1:0]   done_rejected,
   output logic [AW-1:0]               fl_addr,
   output logic [7:0]                  fl_wdata,
   output logic                        fl_we,
   output logic                        fl_re,
   input  logic [7:0]                  fl_rdata
);

   localparam int NSEC = 1 << SECT_BITS;
   localparam int CW   = $clog2(POLL_LIMIT + 1);

   if (AW < 16) begin : g_bad_aw
      $error("nvm_prog_ctrl: AW must hold the 16-bit unlock addresses");
   end
   if (SECT_BITS < 1 || SECT_BITS > AW - 1) begin : g_bad_sect
      $error("nvm_prog_ctrl: SECT_BITS out of range");
   end
   if (POLL_LIMIT < 2) begin : g_bad_limit
      $error("nvm_prog_ctrl: POLL_LIMIT must be at least 2");
   end

   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_ADD, S_C3RD, S_C3EV, S_PRD, S_PEV, S_RST, S_DONE
   } state_e;

   function automatic logic [AW-1:0] sect_base(input logic [SECT_BITS-1:0] s);
      logic [AW-1:0] b;
      b = '0;
      b[AW-1 -: SECT_BITS] = s;
      return b;
   endfunction

   state_e                 state;
   state_e                 add_next;
   nvm_op_e                op_q;
   logic [AW-1:0]          addr_q;
   logic [7:0]             data_q;
   logic [AW-1:0]          poll_q;
   logic                   tog_q;
   logic                   exp7_q;
   logic [NSEC-1:0]        rem_q;
   logic [NSEC-1:0]        rej_q;
   logic [SECT_BITS-1:0]   cur_q;
   logic [STEP_W-1:0]      step_q;
   logic [CW-1:0]          cnt_q;
   logic [1:0]             stage_q;
   logic                   hp_q;
   logic                   prev6_q;
   logic                   pass_q;

   logic [SECT_BITS-1:0]   req_first;
   logic                   req_any;
   logic [SECT_BITS-1:0]   rem_first;
   logic                   rem_any;
   logic [NSEC-1:0]        rem_next;
   logic [NSEC-1:0]        req_rem;
   logic [AW-1:0]          cmd_addr;
   logic [7:0]             cmd_data;
   logic                   rom_last;
   logic                   limit_hit;
   nvm_verdict_e           verdict;

   nvm_sector_pick #(.N(NSEC), .IW(SECT_BITS)) u_pick_req (
      .mask (req_sectors),
      .idx  (req_first),
      .any  (req_any)
   );

   nvm_sector_pick #(.N(NSEC), .IW(SECT_BITS)) u_pick_rem (
      .mask (rem_q),
      .idx  (rem_first),
      .any  (rem_any)
   );

   nvm_cmd_rom #(.AW(AW)) u_rom (
      .op        (op_q),
      .step      (step_q),
      .tgt_addr  (addr_q),
      .tgt_data  (data_q),
      .sect_base (poll_q),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .last      (rom_last)
   );

   assign limit_hit = (cnt_q >= CW'(POLL_LIMIT));

   nvm_status_eval u_eval (
      .toggle    (tog_q),
      .stage     (stage_q),
      .have_prev (hp_q),
      .prev6     (prev6_q),
      .exp7      (exp7_q),
      .limit_hit (limit_hit),
      .rd        (fl_rdata),
      .verdict   (verdict)
   );

   always_comb begin
      rem_next = rem_q;
      rem_next[rem_first] = 1'b0;
      req_rem = req_sectors;
      req_rem[req_first] = 1'b0;
   end

   if (BIT3_CHECK) begin : g_win_check
      assign add_next = S_C3RD;
   end else begin : g_no_win_check
      assign add_next = (|rem_next) ? S_ADD : S_PRD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         op_q    <= OP_PROG;
         addr_q  <= '0;
         data_q  <= '0;
         poll_q  <= '0;
         tog_q   <= 1'b0;
         exp7_q  <= 1'b0;
         rem_q   <= '0;
         rej_q   <= '0;
         cur_q   <= '0;
         step_q  <= '0;
         cnt_q   <= '0;
         stage_q <= '0;
         hp_q    <= 1'b0;
         prev6_q <= 1'b0;
         pass_q  <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (req_valid) begin
               op_q    <= nvm_op_e'(req_op);
               addr_q  <= req_addr;
               data_q  <= req_data;
               tog_q   <= req_toggle;
               exp7_q  <= (req_op == 2'd0) ? req_data[BIT_DONE] : 1'b1;
               rem_q   <= (req_op == 2'd1) ? req_rem : '0;
               rej_q   <= '0;
               pass_q  <= 1'b0;
               step_q  <= '0;
               cnt_q   <= '0;
               stage_q <= '0;
               hp_q    <= 1'b0;
               prev6_q <= 1'b0;
               case (req_op)
                  2'd0:    poll_q <= req_addr;
                  2'd1:    poll_q <= sect_base(req_first);
                  default: poll_q <= '0;
               endcase
               if (req_op == 2'd3 || (req_op == 2'd1 && !req_any))
                  state <= S_DONE;
               else
                  state <= S_CMD;
            end
            S_CMD: begin
               if (rom_last)
                  state <= (op_q == OP_SECT && rem_any) ? S_ADD : S_PRD;
               else
                  step_q <= step_q + 1'b1;
            end
            S_ADD: begin
               cur_q <= rem_first;
               rem_q <= rem_next;
               state <= add_next;
            end
            S_C3RD: state <= S_C3EV;
            S_C3EV: begin
               if (fl_rdata[BIT_WIN]) rej_q[cur_q] <= 1'b1;
               state <= rem_any ? S_ADD : S_PRD;
            end
            S_PRD: begin
               if (stage_q == 2'd0) cnt_q <= cnt_q + 1'b1;
               state <= S_PEV;
            end
            S_PEV: begin
               prev6_q <= fl_rdata[BIT_TOG];
               hp_q    <= 1'b1;
               case (verdict)
                  V_PASS: begin pass_q <= 1'b1; state <= S_DONE; end
                  V_FAIL: state <= S_RST;
                  V_NEXT: begin stage_q <= stage_q + 1'b1; state <= S_PRD; end
                  default: state <= S_PRD;
               endcase
            end
            S_RST:   state <= S_DONE;
            S_DONE:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      fl_we    = 1'b0;
      fl_re    = 1'b0;
      fl_addr  = '0;
      fl_wdata = '0;
      case (state)
         S_CMD:  begin fl_we = 1'b1; fl_addr = cmd_addr; fl_wdata = cmd_data; end
         S_ADD:  begin fl_we = 1'b1; fl_addr = sect_base(rem_first); fl_wdata = CMD_SECT; end
         S_C3RD: begin fl_re = 1'b1; fl_addr = sect_base(cur_q); end
         S_PRD:  begin fl_re = 1'b1; fl_addr = poll_q; end
         S_RST:  begin fl_we = 1'b1; fl_wdata = CMD_RESET; end
         default: ;
      endcase
   end

   assign req_ready     = (state == S_IDLE);
   assign done_valid    = (state == S_DONE);
   assign done_pass     = pass_q;
   assign done_rejected = rej_q;

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!fl_we && !fl_re && !done_valid));

   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));

   p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   p_reset_then_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RST) |=> (done_valid && !done_pass));

   p_pass_from_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && done_pass) |-> $past(state == S_PEV));

   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(POLL_LIMIT));

endmodule

// File: tb/nvm_prog_ctrl_test.sv
module nvm_prog_ctrl_test;

   localparam int AW    = 19;
   localparam int SB    = 3;
   localparam int LIMIT = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic [7:0]    req_sectors = '0;
   logic          req_toggle = 1'b0;
   logic          done_valid, done_pass;
   logic [7:0]    done_rejected;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_wdata;
   logic          fl_we, fl_re;
   logic [7:0]    rd = '0;

   always #4 clk = ~clk;

   nvm_prog_ctrl #(.AW(AW), .SECT_BITS(SB), .POLL_LIMIT(LIMIT), .BIT3_CHECK(1'b1)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data), .req_sectors(req_sectors),
      .req_toggle(req_toggle),
      .done_valid(done_valid), .done_pass(done_pass), .done_rejected(done_rejected),
      .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
      .fl_rdata(rd)
   );

   int nchk = 0;
   int nerr = 0;
   int results_seen = 0;
   string cur_tag = "R1";
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // flash model
   logic          m_clr = 1'b0;
   logic          m_prog = 1'b0;
   logic [7:0]    m_data = '0;
   int            m_mode = 0;
   int            m_busy = 0;
   int            m_open = 99;
   logic [AW-1:0] m_poll = '0;
   int            m_k = 0;
   int            m_other = 0;
   int            m_n30 = 0;

   function automatic logic [7:0] poll_byte(input int k);
      logic       e7;
      logic [7:0] fin;
      logic       t6;
      e7  = m_prog ? m_data[7] : 1'b1;
      fin = m_prog ? m_data : 8'hFF;
      t6  = (k % 2) == 1;
      case (m_mode)
         0: return (k < m_busy) ? {~e7, t6, 6'b0} : fin;
         1: return (k < m_busy) ? {~e7, t6, 6'b0} : {~e7, t6, 1'b1, 5'b0};
         2: begin
            if (k < m_busy)  return {~e7, t6, 6'b0};
            if (k == m_busy) return {~e7, t6, 1'b1, 5'b0};
            return fin;
         end
         default: return {~e7, t6, 6'b0};
      endcase
   endfunction

   always @(posedge clk) begin
      if (m_clr) begin
         m_k <= 0; m_other <= 0; m_n30 <= 0;
      end else begin
         if (fl_we && fl_wdata == 8'h30) m_n30 <= m_n30 + 1;
         if (fl_re) begin
            if (fl_addr == m_poll) begin
               rd  <= poll_byte(m_k);
               m_k <= m_k + 1;
            end else begin
               rd      <= {4'b0, (m_n30 > m_open), 3'b0};
               m_other <= m_other + 1;
            end
         end
      end
   end

   // scoreboard queues
   logic [AW+7:0] wq[$];
   logic [8:0]    rq[$];
   logic          prev_done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (fl_we) begin
            if (wq.size() == 0) begin
               chk(1'b0, {cur_tag, " unexpected write"}, {5'b0, fl_addr, fl_wdata}, 32'h0);
            end else begin
               logic [AW+7:0] e;
               e = wq.pop_front();
               chk({fl_addr, fl_wdata} == e, {cur_tag, " write"}, {5'b0, fl_addr, fl_wdata}, {5'b0, e});
            end
         end
         if (fl_we && fl_re) chk(1'b0, "R12 both strobes", 32'h3, 32'h0);
         if ((fl_we || fl_re) && req_ready) chk(1'b0, "R12 ready during bus cycle", 32'h1, 32'h0);
         if (done_valid) begin
            if (prev_done) chk(1'b0, "R12 done pulse width", 32'h2, 32'h1);
            if (rq.size() == 0) begin
               chk(1'b0, {cur_tag, " unexpected done"}, {23'b0, done_pass, done_rejected}, 32'h0);
            end else begin
               logic [8:0] r;
               r = rq.pop_front();
               chk({done_pass, done_rejected} == r, {cur_tag, " result"},
                   {23'b0, done_pass, done_rejected}, {23'b0, r});
            end
            results_seen++;
         end
         prev_done <= done_valid;
      end
   end

   task automatic push_w(input logic [AW-1:0] a, input logic [7:0] d);
      wq.push_back({a, d});
   endtask

   task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                         input logic [7:0] mask, input logic tog, input int mode, input int busy,
                         input int open_n, input logic exp_pass, input logic [7:0] exp_rej,
                         input int exp_poll, input int exp_other, input string tag);
      int target;
      logic valid_job;
      cur_tag = tag;
      m_prog = (op == 2'd0);
      m_data = d;
      m_mode = mode;
      m_busy = busy;
      m_open = open_n;
      valid_job = (op == 2'd0) || (op == 2'd2) || (op == 2'd1 && mask != 0);
      m_poll = '0;
      if (op == 2'd0) m_poll = a;
      if (op == 2'd1) begin
         for (int s = 7; s >= 0; s--) if (mask[s]) m_poll = {3'(s), 16'h0};
      end
      @(negedge clk); m_clr = 1'b1;
      @(negedge clk); m_clr = 1'b0;
      if (valid_job) begin
         push_w(19'h05555, 8'hAA);
         push_w(19'h02AAA, 8'h55);
         if (op == 2'd0) begin
            push_w(19'h05555, 8'hA0);
            push_w(a, d);
         end else begin
            push_w(19'h05555, 8'h80);
            push_w(19'h05555, 8'hAA);
            push_w(19'h02AAA, 8'h55);
            if (op == 2'd2) push_w(19'h05555, 8'h10);
            else for (int s = 0; s < 8; s++) if (mask[s]) push_w({3'(s), 16'h0}, 8'h30);
         end
         if (!exp_pass) push_w(19'h0, 8'hF0);
      end
      rq.push_back({exp_pass, exp_rej});
      target = results_seen + 1;
      req_op = op; req_addr = a; req_data = d; req_sectors = mask; req_toggle = tog;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      wait (results_seen == target);
      @(negedge clk);
      chk(wq.size() == 0, {tag, " writes left"}, wq.size(), 32'h0);
      chk(m_k == exp_poll, {tag, " status reads at poll address"}, m_k, exp_poll);
      chk(m_other == exp_other, {tag, " reads elsewhere"}, m_other, exp_other);
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(fl_we == 1'b0 && fl_re == 1'b0, "R1 strobes after reset", {fl_we, fl_re}, 0);
      chk(done_valid == 1'b0, "R1 done after reset", done_valid, 0);

      // R2 R5 byte write, data poll, finishes after three busy reads
      run_op(2'd0, 19'h12345, 8'h5A, 8'h00, 1'b0, 0, 3, 99, 1'b1, 8'h00, 4, 0, "R2 R5");
      // R6 bit5 seen then bit7 matches on the recheck
      run_op(2'd0, 19'h00F0F, 8'hA5, 8'h00, 1'b0, 2, 2, 99, 1'b1, 8'h00, 4, 0, "R6 late");
      // R6 R8 bit5 seen, recheck still busy -> fail and reset write
      run_op(2'd0, 19'h7FFFF, 8'h3C, 8'h00, 1'b0, 1, 1, 99, 1'b0, 8'h00, 3, 0, "R6 R8 hang");
      // R9 never completes
      run_op(2'd0, 19'h00001, 8'h00, 8'h00, 1'b0, 3, 0, 99, 1'b0, 8'h00, LIMIT, 0, "R9 limit");
      // R4 chip erase
      run_op(2'd2, 19'h0, 8'h00, 8'h00, 1'b0, 0, 4, 99, 1'b1, 8'h00, 5, 0, "R4 chip");
      // R3 R10 sectors 2,5,7, window open for all
      run_op(2'd1, 19'h0, 8'h00, 8'hA4, 1'b0, 0, 2, 99, 1'b1, 8'h00, 3, 2, "R3 R10 multi");
      // R10 sectors 0,1,3, window closes after two sector writes
      run_op(2'd1, 19'h0, 8'h00, 8'h0B, 1'b0, 0, 0, 2, 1'b1, 8'h08, 1, 2, "R10 window");
      // R11 empty mask and reserved code
      run_op(2'd1, 19'h0, 8'h00, 8'h00, 1'b0, 0, 0, 99, 1'b0, 8'h00, 0, 0, "R11 empty");
      run_op(2'd3, 19'h0, 8'h00, 8'hFF, 1'b0, 0, 0, 99, 1'b0, 8'h00, 0, 0, "R11 reserved");
      // R7 toggle mode
      run_op(2'd0, 19'h0ABCD, 8'h81, 8'h00, 1'b1, 0, 4, 99, 1'b1, 8'h00, 6, 0, "R7 toggle ok");
      run_op(2'd1, 19'h0, 8'h00, 8'h40, 1'b1, 1, 0, 99, 1'b0, 8'h00, 4, 0, "R7 R8 toggle hang");
      run_op(2'd2, 19'h0, 8'h00, 8'h00, 1'b1, 2, 2, 99, 1'b1, 8'h00, 5, 0, "R7 toggle late");
      run_op(2'd0, 19'h00100, 8'h11, 8'h00, 1'b1, 3, 0, 99, 1'b0, 8'h00, LIMIT, 0, "R9 toggle limit");

      repeat (4) @(negedge clk);
      chk(rq.size() == 0, "R12 results pending", rq.size(), 0);
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule